// File: doc/BRIEF.md
# SPI Fault-Reporting Slave with Frame-Length Check

This block is the serial port of a multi-channel low-side driver controller. A host pulls chip select low, clocks in one or more 16-bit command words, and at the same time reads out a latched word of per-channel fault codes. The command is handed on only if the transfer had a legal length. The fault latch is handed to the serial shifter when chip select falls, and refreshed when it rises. An active-low, open-drain-style fault flag tells the host when there is something to read.

All serial inputs are sampled in the system clock domain through two-flop synchronizers with edge detection. Serial clock edges are therefore seen a few system clocks late, and the serial clock must be much slower than `clk`. The live fault inputs are taken to be synchronous to `clk`. When `so_oe` is low, the pad driver holds `so` in high impedance. Bits shifted in on SI come back out on SO 16 serial clocks later, so slaves can be chained.

Top module: `spi_fault_slave`

## Requirements
- R1: A chip-select low period is a valid frame only if it held a nonzero whole multiple of 16 serial clock rising edges. Any other count is a frame error, and that includes zero.
- R2: Both directions move MSB first. SI is sampled on the serial clock rising edge, and SO changes after the serial clock falling edge.
- R3: When chip select falls, the bit count restarts, the latched fault word is loaded into the output shifter, and `flt_n` is forced high until chip select rises again.
- R4: While chip select is high, a channel whose latched code is 00 takes its live code. While chip select is low, the latch does not change.
- R5: When chip select rises after a valid frame, the last 16 bits received appear on `cmd_out` together with a one-cycle `cmd_stb`. At the same edge the latch is overwritten with the live fault codes.
- R6: When chip select rises after a frame error, `cmd_out` keeps its value and `cmd_stb` stays low. Latched codes are kept and are read out by the next valid frame.
- R7: `flt_n` is low only when the flag is enabled and at least one latched code is nonzero. A frame error on its own never pulls it low.
- R8: In the fault word, channel k uses bits 2k+1:2k (channel 0 at the LSB) and bits 15:12 are zero. The codes are 00 none, 01 short to ground, 10 open load, 11 shorted load.
- R9: `so_oe` is low whenever the synchronized chip select is high. In a frame longer than 16 bits, each SO bit from bit 16 onward repeats the SI bit sent 16 serial clocks earlier.
- R10: After reset, `cmd_out` is zero, `cmd_stb` is low, the latch is clear, `flt_n` is high and `so_oe` is low.
- R11: The bit counter saturates at its maximum, so an overlong burst is a frame error and never wraps to an apparent valid count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| csb | input | 1 | Chip select, active low |
| sclk | input | 1 | Serial clock, idle low |
| si | input | 1 | Serial data in |
| so | output | 1 | Serial data out |
| so_oe | output | 1 | Output enable for `so` |
| fault_in | input | NCH*CODE_W | Live fault codes, channel 0 in the low bits |
| cmd_out | output | WORD_W | Last committed command word |
| cmd_stb | output | 1 | One-cycle commit strobe |
| flt_n | output | 1 | Fault flag, active low |

## Verification
The bench builds the block with WORD_W=16, six 2-bit channels and a 6-bit frame counter that saturates at 63. This makes an 80-bit burst reachable in a short run. Without saturation, that burst would wrap to a count of 16 and be accepted, so it separates a saturating counter from a wrapping one. Frames of 0, 15, 16, 17, 32, 48 and 80 bits exercise both the accept and the reject paths. The 32-bit frame shows the daisy-chain pass-through on SO.

// File: rtl/spi_fault_slave.sv
module spi_fault_slave #(
  parameter int WORD_W = 16,
  parameter int NCH    = 6,
  parameter int CODE_W = 2,
  parameter int CNT_W  = 8
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    csb,
  input  logic                    sclk,
  input  logic                    si,
  output logic                    so,
  output logic                    so_oe,
  input  logic [NCH*CODE_W-1:0]   fault_in,
  output logic [WORD_W-1:0]       cmd_out,
  output logic                    cmd_stb,
  output logic                    flt_n
);
  localparam int LAT_W = NCH * CODE_W;
  localparam int BIT_W = $clog2(WORD_W);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [1:0] csb_sy, sclk_sy, si_sy;
  logic       csb_q, sclk_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [WORD_W-1:0] rx_q, tx_q;
  logic [LAT_W-1:0]  lat_q, lat_fill;
  logic       flag_en;

  wire csb_s   = csb_sy[1];
  wire cs_fall = csb_q & ~csb_s;
  wire cs_rise = ~csb_q & csb_s;
  wire sc_rise = sclk_sy[1] & ~sclk_q & ~csb_s;
  wire sc_fall = ~sclk_sy[1] & sclk_q & ~csb_s;
  wire frame_ok = (cnt_q != '0) && (cnt_q[BIT_W-1:0] == '0) && (cnt_q != CNT_MAX);

  for (genvar g = 0; g < NCH; g++) begin : g_fill
    assign lat_fill[g*CODE_W +: CODE_W] = (lat_q[g*CODE_W +: CODE_W] == '0)
                                          ? fault_in[g*CODE_W +: CODE_W]
                                          : lat_q[g*CODE_W +: CODE_W];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      csb_sy  <= 2'b11;
      sclk_sy <= 2'b00;
      si_sy   <= 2'b00;
      csb_q   <= 1'b1;
      sclk_q  <= 1'b0;
    end else begin
      csb_sy  <= {csb_sy[0], csb};
      sclk_sy <= {sclk_sy[0], sclk};
      si_sy   <= {si_sy[0], si};
      csb_q   <= csb_s;
      sclk_q  <= sclk_sy[1];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      rx_q  <= '0;
      tx_q  <= '0;
    end else if (cs_fall) begin
      cnt_q <= '0;
      tx_q  <= {{(WORD_W-LAT_W){1'b0}}, lat_q};
    end else begin
      if (sc_rise) begin
        rx_q <= {rx_q[WORD_W-2:0], si_sy[1]};
        if (cnt_q != CNT_MAX) cnt_q <= cnt_q + 1'b1;
      end
      if (sc_fall) tx_q <= {tx_q[WORD_W-2:0], rx_q[0]};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd_out <= '0;
      cmd_stb <= 1'b0;
      lat_q   <= '0;
      flag_en <= 1'b1;
    end else begin
      cmd_stb <= cs_rise & frame_ok;
      if (cs_rise & frame_ok) cmd_out <= rx_q;
      if (cs_rise & frame_ok) lat_q <= fault_in;
      else if (csb_s)         lat_q <= lat_fill;
      if (cs_fall)      flag_en <= 1'b0;
      else if (cs_rise) flag_en <= 1'b1;
    end
  end

  assign so    = tx_q[WORD_W-1];
  assign so_oe = ~csb_s;
  assign flt_n = ~(flag_en & (|lat_q));
endmodule

// File: rtl/spi_fault_slave_chk.sv
module spi_fault_slave_chk #(
  parameter int WORD_W = 16,
  parameter int LAT_W  = 12
) (
  input logic              clk,
  input logic              rst_n,
  input logic              so_oe,
  input logic              flt_n,
  input logic              cmd_stb,
  input logic [WORD_W-1:0] cmd_out,
  input logic [LAT_W-1:0]  lat
);
  assert_stb_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_stb |=> !cmd_stb);
  assert_stb_idle_R5: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_stb |-> !so_oe);
  assert_cmd_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_out != $past(cmd_out)) |-> cmd_stb);
  assert_flag_quiet_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (so_oe && $past(so_oe)) |-> flt_n);
  assert_latch_frozen_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (so_oe && $past(so_oe)) |-> $stable(lat));
  assert_flag_cause_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !flt_n |-> (lat != '0));
endmodule

bind spi_fault_slave spi_fault_slave_chk #(.WORD_W(WORD_W), .LAT_W(NCH*CODE_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .so_oe(so_oe), .flt_n(flt_n),
  .cmd_stb(cmd_stb), .cmd_out(cmd_out), .lat(lat_q)
);

// File: tb/spi_fault_slave_tb.sv
module spi_fault_slave_tb;
  localparam int CLK_PERIOD = 10;
  localparam int HALF = 8;
  localparam int NCH = 6;

  logic clk = 0, rst_n = 0, csb = 1, sclk = 0, si = 0;
  logic [11:0] fault_in = '0;
  logic so, so_oe, cmd_stb, flt_n;
  logic [15:0] cmd_out;
  int tests = 0, fails = 0, stb_cnt = 0, cycles = 0;
  logic h1 = 1, h2 = 1;
  int exp_lat[NCH];
  logic [15:0] exp_cmd = '0;

  spi_fault_slave #(.WORD_W(16), .NCH(NCH), .CODE_W(2), .CNT_W(6)) u_dut (
    .clk(clk), .rst_n(rst_n), .csb(csb), .sclk(sclk), .si(si), .so(so), .so_oe(so_oe),
    .fault_in(fault_in), .cmd_out(cmd_out), .cmd_stb(cmd_stb), .flt_n(flt_n));

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(posedge clk) begin
    h2 <= h1; h1 <= csb;
    if (rst_n && cmd_stb) stb_cnt++;
    cycles++;
    if (cycles > 150000) begin
      fails++;
      $display("FAIL watchdog: actual=%0d cycles expected<150000", cycles);
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  // R9 per-clock model: output enable follows chip select two samples back
  always @(negedge clk) if (rst_n) begin
    tests++;
    if (so_oe !== ~h2) begin
      fails++;
      $display("FAIL R9 so_oe: actual=%b expected=%b", so_oe, ~h2);
    end
  end

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [15:0] lat_word();
    logic [15:0] w = '0;
    for (int k = 0; k < NCH; k++) w[2*k +: 2] = exp_lat[k][1:0];
    return w;
  endfunction

  function automatic bit lat_any();
    for (int k = 0; k < NCH; k++) if (exp_lat[k] != 0) return 1;
    return 0;
  endfunction

  task automatic idle_capture();
    for (int k = 0; k < NCH; k++) if (exp_lat[k] == 0) exp_lat[k] = int'(fault_in[2*k +: 2]);
  endtask

  task automatic set_faults(input logic [11:0] v);
    @(negedge clk); fault_in = v;
    repeat (6) @(negedge clk);
    if (csb) idle_capture();
  endtask

  task automatic xfer(input int n, input logic [255:0] din, output logic [255:0] dout,
                      input int chg_at, input logic [11:0] chg_val);
    dout = '0;
    @(negedge clk); csb = 0;
    repeat (HALF) @(negedge clk);
    for (int i = 0; i < n; i++) begin
      si = din[n-1-i];
      if (i == chg_at) fault_in = chg_val;
      repeat (HALF) @(negedge clk);
      dout[n-1-i] = so;
      sclk = 1;
      repeat (HALF) @(negedge clk);
      sclk = 0;
    end
    repeat (HALF) @(negedge clk);
    check(flt_n == 1'b1, "R3 flag held off in frame", flt_n, 1);
    csb = 1; si = 0;
    repeat (10) @(negedge clk);
    if (n > 0 && n % 16 == 0 && n < 63) begin
      exp_cmd = din[15:0];
      for (int k = 0; k < NCH; k++) exp_lat[k] = int'(fault_in[2*k +: 2]);
    end else idle_capture();
  endtask

  task automatic after_frame(input string tag, input int stb_before, input bit valid);
    check(cmd_out == exp_cmd, {tag, " cmd_out"}, cmd_out, exp_cmd);
    check(stb_cnt == stb_before + (valid ? 1 : 0), {tag, " strobe count"}, stb_cnt, stb_before + (valid ? 1 : 0));
    check(flt_n == !lat_any(), {tag, " R7 flag"}, flt_n, !lat_any());
  endtask

  initial begin
    logic [255:0] d;
    int s;
    for (int k = 0; k < NCH; k++) exp_lat[k] = 0;
    repeat (4) @(negedge clk);
    // R10 reset state
    check(flt_n == 1 && so_oe == 0 && cmd_out == 0 && cmd_stb == 0, "R10 reset", {flt_n, so_oe, cmd_stb}, 3'b100);
    rst_n = 1;
    repeat (4) @(negedge clk);

    // R4 idle capture sets flag: ch0=01, ch3=11
    set_faults(12'h0C1);
    check(flt_n == 0, "R4 idle capture flag", flt_n, 0);

    // R2 R3 R8 valid frame reads latched word; fault change mid-frame is not latched (R4)
    s = stb_cnt;
    xfer(16, 256'hA5C3, d, 5, 12'h8C1);
    check(d[15:0] == 16'h00C1, "R8 R2 fault word on SO", d[15:0], 16'h00C1);
    after_frame("R5 valid 16", s, 1);

    // R5 latch replaced: clear faults, old 0x8C1 still read, then cleared
    set_faults(12'h000);
    s = stb_cnt;
    xfer(16, 256'h1234, d, -1, 0);
    check(d[15:0] == 16'h08C1, "R5 latch refreshed at rise", d[15:0], 16'h08C1);
    after_frame("R5 clear old", s, 1);
    check(flt_n == 1, "R5 flag clear after refresh", flt_n, 1);

    // R6 frame errors keep latch: ch1=10 captured, then live cleared
    set_faults(12'h008);
    set_faults(12'h000);
    s = stb_cnt;
    xfer(15, 256'h7FFF, d, -1, 0);
    after_frame("R1 R6 15 bits", s, 0);
    s = stb_cnt;
    xfer(0, '0, d, -1, 0);
    after_frame("R1 R6 0 bits", s, 0);
    s = stb_cnt;
    xfer(17, 256'h1FFFF, d, -1, 0);
    after_frame("R1 R6 17 bits", s, 0);
    s = stb_cnt;
    xfer(16, 256'h0F0F, d, -1, 0);
    check(d[15:0] == 16'h0008, "R6 kept latch read out", d[15:0], 16'h0008);
    after_frame("R5 valid after errors", s, 1);

    // R7 frame error with no fault leaves flag high
    s = stb_cnt;
    xfer(15, 256'h1234, d, -1, 0);
    after_frame("R7 error alone", s, 0);
    check(flt_n == 1, "R7 error does not set flag", flt_n, 1);

    // R9 daisy chain 32 bits, ch2=01
    set_faults(12'h010);
    s = stb_cnt;
    xfer(32, 256'hBEEFCAFE, d, -1, 0);
    check(d[31:16] == 16'h0010, "R9 first word", d[31:16], 16'h0010);
    check(d[15:0] == 16'hBEEF, "R9 pass-through", d[15:0], 16'hBEEF);
    after_frame("R1 R5 32 bits", s, 1);

    // R11 80-bit burst saturates and is rejected
    s = stb_cnt;
    xfer(80, {176'h0, 80'h1111_2222_3333_4444_5555}, d, -1, 0);
    after_frame("R11 80 bits", s, 0);

    // R1 48-bit frame valid
    s = stb_cnt;
    xfer(48, 256'h9999_8888_7777, d, -1, 0);
    check(d[47:32] == 16'h0010, "R8 word in 48 frame", d[47:32], 16'h0010);
    after_frame("R1 48 bits", s, 1);

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule